// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit forms the memory address for load and store operations and for the two address-load operations of a 32-bit processor. It takes the instruction word, the program counter as it stands after fetch (already advanced by 4) and the value read from the base register. It produces the effective address, the register-file index of the base register, and a code that names the addressing mode that was applied.

There are two addressing families. The displacement family adds a sign-extended 17-bit field to a base register. When the base index is zero it uses the field alone, so register 0 is never read as a base. The PC-relative family adds a sign-extended 22-bit field to the program counter.

The base index is combinational, so the register file can be read in the same cycle. The address and the mode code pass through an output register when `OUT_REG` is 1, which is the default. All address arithmetic wraps modulo 2^32.

Top module: `eagen_top`

## Requirements
- R1: `baseIdx` always equals instruction bits 21..17, combinationally and in the same cycle, whatever the opcode (opcode is bits 31..27).
- R2: For opcodes 1, 3 and 5 with bits 21..17 equal to zero, the address is bits 16..0 sign-extended to 32 bits, `baseVal` is ignored, and the mode code is 2'b10. A set bit 16 gives 0xFFFF0000..0xFFFFFFFF and a clear bit 16 gives 0x00000000..0x0000FFFF.
- R3: For opcodes 1, 3 and 5 with bits 21..17 nonzero, the address is `baseVal` plus bits 16..0 sign-extended, and the mode code is 2'b01.
- R4: For opcodes 2, 4 and 6, the address is `pcNext` plus bits 21..0 sign-extended, `baseVal` is ignored, and the mode code is 2'b11.
- R5: For any other opcode, the mode code is 2'b00 and the address is zero.
- R6: With `OUT_REG`=1, `effAddr` and `addrMode` reflect the inputs of the previous rising clock edge. While `rstN` is low they read zero and 2'b00.
- R7: Sums wrap modulo 2^32 with no overflow indication. A negative displacement below the base or below the PC wraps around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| instrWord | input | 32 | Instruction word being executed |
| pcNext | input | 32 | Program counter after the fetch increment |
| baseVal | input | 32 | Value read from register `baseIdx` |
| baseIdx | output | 5 | Register-file read index for the base |
| effAddr | output | 32 | Effective address or loaded address value |
| addrMode | output | 2 | 00 none, 01 base+disp, 10 absolute, 11 PC-relative |

## Verification
The hardest cases to reach are the ends of each displacement range and the sums that wrap past 2^32. These appear only when the sign bit of a field lines up with a chosen base or PC. The vector table places the extreme short and long displacements (0x0FFFF, 0x10000, 0x1FFFF, 0x1FFFFF, 0x200000) against bases and PCs picked so that the sum crosses zero or the top of the address space. Other vectors put a nonzero base value on an absolute or relative operation, or a nonzero rb field on a PC-relative one, so that any leak of the base into the sum shows up at the address output.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_BASE = 2'b01,
    MODE_ABS  = 2'b10,
    MODE_REL  = 2'b11
  } eaMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    active;   // an address is produced this cycle
    logic    usePc;    // PC plus long field
    logic    addBase;  // base register joins the sum
    eaMode_e mode;
  } eaStrobe_t;

endpackage

// File: rtl/eagen_ctrl.sv
module eagen_ctrl
  import eagen_pkg::*;
#(
  parameter int OP_W  = 5,
  parameter int IDX_W = 5
) (
  input  logic [OP_W-1:0]  opCode,
  input  logic [IDX_W-1:0] rbIdx,
  output eaStrobe_t        strobe
);

  localparam logic [OP_W-1:0] OP_LOAD     = OP_W'(1);
  localparam logic [OP_W-1:0] OP_LOAD_REL = OP_W'(2);
  localparam logic [OP_W-1:0] OP_STORE    = OP_W'(3);
  localparam logic [OP_W-1:0] OP_STOR_REL = OP_W'(4);
  localparam logic [OP_W-1:0] OP_ADDR     = OP_W'(5);
  localparam logic [OP_W-1:0] OP_ADDR_REL = OP_W'(6);

  logic rbZero;
  assign rbZero = (rbIdx == '0);

  always_comb begin
    strobe = '{active: 1'b0, usePc: 1'b0, addBase: 1'b0, mode: MODE_NONE};
    unique case (opCode)
      OP_LOAD, OP_STORE, OP_ADDR: begin
        strobe.active  = 1'b1;
        strobe.addBase = !rbZero;
        strobe.mode    = rbZero ? MODE_ABS : MODE_BASE;
      end
      OP_LOAD_REL, OP_STOR_REL, OP_ADDR_REL: begin
        strobe.active = 1'b1;
        strobe.usePc  = 1'b1;
        strobe.mode   = MODE_REL;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/eagen_dp.sv
module eagen_dp
  import eagen_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 17,
  parameter int LONG_W  = 22,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  eaStrobe_t          strobe,
  input  logic [SHORT_W-1:0] shortDisp,
  input  logic [LONG_W-1:0]  longDisp,
  input  logic [DATA_W-1:0]  pcNext,
  input  logic [DATA_W-1:0]  baseVal,
  output logic [DATA_W-1:0]  effAddr,
  output logic [1:0]         addrMode
);

  localparam int SHORT_PAD = DATA_W - SHORT_W;
  localparam int LONG_PAD  = DATA_W - LONG_W;

  logic [DATA_W-1:0] shortExt, longExt, opA, offs, sumVal, nextAddr;
  logic [1:0]        nextMode;

  assign shortExt = {{SHORT_PAD{shortDisp[SHORT_W-1]}}, shortDisp};
  assign longExt  = {{LONG_PAD{longDisp[LONG_W-1]}}, longDisp};

  always_comb begin
    if (strobe.usePc) begin
      opA  = pcNext;
      offs = longExt;
    end else begin
      opA  = strobe.addBase ? baseVal : '0;
      offs = shortExt;
    end
  end

  assign sumVal   = opA + offs;  // wraps modulo 2^DATA_W
  assign nextAddr = strobe.active ? sumVal : '0;
  assign nextMode = strobe.mode;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          effAddr  <= '0;
          addrMode <= MODE_NONE;
        end else begin
          effAddr  <= nextAddr;
          addrMode <= nextMode;
        end
      end
    end else begin : g_comb
      assign effAddr  = nextAddr;
      assign addrMode = nextMode;
    end
  endgenerate

endmodule

// File: rtl/eagen_top.sv
module eagen_top
  import eagen_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OP_W    = 5,
  parameter int IDX_W   = 5,
  parameter int SHORT_W = 17,
  parameter int LONG_W  = 22,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] pcNext,
  input  logic [DATA_W-1:0] baseVal,
  output logic [IDX_W-1:0]  baseIdx,
  output logic [DATA_W-1:0] effAddr,
  output logic [1:0]        addrMode
);

  localparam int OP_LSB = DATA_W - OP_W;
  localparam int RA_LSB = OP_LSB - IDX_W;
  localparam int RB_LSB = RA_LSB - IDX_W;

  eaStrobe_t strobe;
  logic      unusedRaBits;

  assign unusedRaBits = ^instrWord[RA_LSB +: IDX_W];
  assign baseIdx      = instrWord[RB_LSB +: IDX_W];

  eagen_ctrl #(.OP_W(OP_W), .IDX_W(IDX_W)) ctrl_i (
    .opCode (instrWord[OP_LSB +: OP_W]),
    .rbIdx  (instrWord[RB_LSB +: IDX_W]),
    .strobe (strobe)
  );

  eagen_dp #(
    .DATA_W(DATA_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W), .OUT_REG(OUT_REG)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .shortDisp (instrWord[SHORT_W-1:0]),
    .longDisp  (instrWord[LONG_W-1:0]),
    .pcNext    (pcNext),
    .baseVal   (baseVal),
    .effAddr   (effAddr),
    .addrMode  (addrMode)
  );

endmodule

// File: rtl/eagen_chk.sv
module eagen_chk #(
  parameter int DATA_W  = 32,
  parameter int OP_W    = 5,
  parameter int IDX_W   = 5,
  parameter int LONG_W  = 22,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] instrWord,
  input logic [DATA_W-1:0] pcNext,
  input logic [IDX_W-1:0]  baseIdx,
  input logic [DATA_W-1:0] effAddr,
  input logic [1:0]        addrMode
);

  localparam int OP_LSB = DATA_W - OP_W;
  localparam int HI_W   = DATA_W - LONG_W + 1;

  logic [OP_W-1:0]   opSeen;
  logic [IDX_W-1:0]  idxSeen;
  logic [DATA_W-1:0] pcSeen, relDiff;

  generate
    if (OUT_REG) begin : g_lag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          opSeen  <= '0;
          idxSeen <= '0;
          pcSeen  <= '0;
        end else begin
          opSeen  <= instrWord[OP_LSB +: OP_W];
          idxSeen <= baseIdx;
          pcSeen  <= pcNext;
        end
      end
    end else begin : g_now
      assign opSeen  = instrWord[OP_LSB +: OP_W];
      assign idxSeen = baseIdx;
      assign pcSeen  = pcNext;
    end
  endgenerate

  assign relDiff = effAddr - pcSeen;

  a_r5_none_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addrMode == 2'b00) |-> (effAddr == '0));

  a_r2_abs_range: assert property (@(posedge clk) disable iff (!rstN)
    (addrMode == 2'b10) |-> ((effAddr[DATA_W-1:16] == '0) || (&effAddr[DATA_W-1:16])));

  a_r2_abs_idx_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addrMode == 2'b10) |-> (idxSeen == '0));

  a_r3_base_idx_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (addrMode == 2'b01) |-> (idxSeen != '0));

  a_r4_rel_window: assert property (@(posedge clk) disable iff (!rstN)
    (addrMode == 2'b11) |->
      ((relDiff[DATA_W-1 -: HI_W] == '0) || (&relDiff[DATA_W-1 -: HI_W])));

  a_r5_mode_from_op: assert property (@(posedge clk) disable iff (!rstN)
    ((opSeen == 0) || (opSeen > 6)) |-> (addrMode == 2'b00));

  a_r4_rel_ops: assert property (@(posedge clk) disable iff (!rstN)
    ((opSeen == 2) || (opSeen == 4) || (opSeen == 6)) |-> (addrMode == 2'b11));

endmodule

bind eagen_top eagen_chk #(
  .DATA_W(DATA_W), .OP_W(OP_W), .IDX_W(IDX_W), .LONG_W(LONG_W), .OUT_REG(OUT_REG)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .instrWord (instrWord),
  .pcNext    (pcNext),
  .baseIdx   (baseIdx),
  .effAddr   (effAddr),
  .addrMode  (addrMode)
);

// File: tb/eagen_tb.sv
module eagen_top_tb_top;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] pc;
    logic [31:0] base;
    logic [31:0] addr;
    logic [1:0]  mode;
  } vec_t;

  localparam int NV = 14;
  // instr, pc, base, expected address, expected mode
  localparam vec_t VECS [NV] = '{
    '{32'h0946000B, 32'h00000040, 32'h00000100, 32'h0000010B, 2'b01}, // R3 ld base+11
    '{32'h0800FFFF, 32'h00000040, 32'h12345678, 32'h0000FFFF, 2'b10}, // R2 top of positive range
    '{32'h18010000, 32'h00000040, 32'h0000DEAD, 32'hFFFF0000, 2'b10}, // R2 bottom of negative range
    '{32'h2801FFFF, 32'h00000040, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'b10}, // R2 la -1
    '{32'h18120000, 32'h00000040, 32'h12345678, 32'h12345678, 2'b01}, // R3 zero disp
    '{32'h2803FFF0, 32'h00000040, 32'h00000010, 32'h00000000, 2'b01}, // R3 negative disp
    '{32'h083E0010, 32'h00000040, 32'hFFFFFFF8, 32'h00000008, 2'b01}, // R7 wrap upward
    '{32'h103FFFD0, 32'h00001000, 32'h0000AAAA, 32'h00000FD0, 2'b11}, // R4 ldr -48
    '{32'h201FFFFF, 32'h00400000, 32'h00000000, 32'h005FFFFF, 2'b11}, // R4 max forward
    '{32'h30200000, 32'h00100000, 32'h00000077, 32'hFFF00000, 2'b11}, // R7 rel wraps below 0
    '{32'h10060004, 32'h00000200, 32'hFFFF0000, 32'h00060204, 2'b11}, // R4 rb field ignored
    '{32'h0000ABCD, 32'h00000044, 32'h00000055, 32'h00000000, 2'b00}, // R5 opcode 0
    '{32'hF8FFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 2'b00}, // R5 opcode 31
    '{32'h38000010, 32'h00000010, 32'h00000010, 32'h00000000, 2'b00}  // R5 opcode 7
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrWord = '0, pcNext = '0, baseVal = '0;
  logic [4:0]  baseIdx;
  logic [31:0] effAddr;
  logic [1:0]  addrMode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  eagen_top dut_i (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .pcNext(pcNext),
    .baseVal(baseVal), .baseIdx(baseIdx), .effAddr(effAddr), .addrMode(addrMode)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic applyVec(input vec_t v);
    instrWord = v.instr;
    pcNext    = v.pc;
    baseVal   = v.base;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    // R6 reset state
    repeat (3) @(negedge clk);
    check32("R6 reset addr", effAddr, 32'h0);
    check32("R6 reset mode", {30'h0, addrMode}, 32'h0);
    applyVec(VECS[0]);
    @(negedge clk);
    check32("R6 held in reset", effAddr, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      applyVec(VECS[i]);
      #1;
      // R1 combinational index
      check32("R1 base index", {27'h0, baseIdx}, {27'h0, VECS[i].instr[21:17]});
      if (i > 0)  // R6 output still shows the previous vector before the edge
        check32("R6 latency", effAddr, VECS[i-1].addr);
      @(negedge clk);
      check32("R2/R3/R4/R5/R7 address", effAddr, VECS[i].addr);
      check32("R2/R3/R4/R5 mode", {30'h0, addrMode}, {30'h0, VECS[i].mode});
    end

    // R2 absolute: changing base must not move the address
    @(negedge clk);
    applyVec(VECS[1]);
    baseVal = 32'h7FFF0000;
    @(negedge clk);
    check32("R2 base ignored", effAddr, 32'h0000FFFF);

    // R4 relative: changing base must not move the address
    applyVec(VECS[7]);
    baseVal = 32'h80000000;
    @(negedge clk);
    check32("R4 base ignored", effAddr, 32'h00000FD0);

    // R7 base plus positive disp wraps from the top
    instrWord = 32'h0802FFFF; baseVal = 32'hFFFFFFFF;  // op1 rb1 disp 0x0FFFF
    @(negedge clk);
    check32("R7 wrap", effAddr, 32'h0000FFFE);

    // R6 asynchronous reset mid-run
    rstN = 1'b0;
    #1;
    check32("R6 async reset addr", effAddr, 32'h0);
    check32("R6 async reset mode", {30'h0, addrMode}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule